// File: doc/BRIEF.md
# Shadowed SRAM Store/Recall Controller

This block is the control core of a byte-wide static RAM that keeps a nonvolatile shadow copy of its whole array. It decodes a chip select, a write strobe and an active-low store line into idle, read, write and store modes. It remembers whether any write has landed since the last nonvolatile transfer. It also sequences the two bulk transfers: STORE copies the working array into the shadow copy, and RECALL copies the shadow back into the working array. Both arrays are internal memories, and each transfer walks them one word per clock.

A STORE is requested either by holding the store line low or by the supply-good input falling. It is carried out only when the working array holds unsaved writes. After a store, or after a request that was skipped because nothing was written, the block refuses every access until the store line returns high and a recovery interval has passed. A RECALL runs by itself each time supply-good rises. A reset models abrupt loss of power with no energy left to save: the shadow copy is kept and nothing is copied.

The bidirectional store/busy line is split into an input (`st_line_n`) and an open-drain-style output (`busy_n`). The outputs' high-impedance state is shown by `rdata_en` being low. All durations are parameters counted in clock cycles. `STORE_CYC` must be at least the array depth, and every other duration must be at least 1.

Top module: `nvram_keeper`

## Requirements
- R1: After reset, `rdata_en` is 0 and `busy_n` is 1. No read succeeds while `pwr_good` is low.
- R2: With the store line high, `sel_n`=0 and `wr_n`=0 writes `wdata` at `addr`. `sel_n`=0 and `wr_n`=1 returns the stored word on `rdata` with `rdata_en`=1 one clock later. `sel_n`=1 leaves `rdata_en` at 0.
- R3: While `st_line_n` is low, no read or write reaches the working array, whatever `sel_n` and `wr_n` are.
- R4: A store request is recognised only after `st_line_n` has been sampled low on REQ_MIN consecutive edges. A shorter pulse starts nothing. On recognition with unsaved data, `busy_n` falls at the (REQ_MIN+1)-th clock after the line falls.
- R5: A recognised request with unsaved writes holds `busy_n` low for DRAIN_CYC+STORE_CYC cycles: a settle phase, then a copy of every word into the shadow.
- R6: A recognised request with no unsaved writes leaves `busy_n` high and the shadow copy unchanged.
- R7: After a store or a skipped request, access stays blocked until the store line is high. A read held from the cycle the line rises returns `rdata_en`=1 at the (RECOV_CYC+3)-th clock.
- R8: Any accepted write marks the array as unsaved. A completed store or recall clears that mark.
- R9: When `pwr_good` falls in normal operation with unsaved writes, `busy_n` falls at the next clock and stays low STORE_CYC cycles; the block then stays off. With no unsaved writes it goes off without a store.
- R10: When `pwr_good` rises while off, `busy_n` falls at the next clock and stays low for one cycle per word. The block then reads back exactly the shadow contents.
- R11: Reset copies nothing: data written after the last store is lost, and the recall that follows restores the shadow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (abrupt power loss) |
| pwr_good | input | 1 | Supply-good indication |
| sel_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe |
| st_line_n | input | 1 | Store line as sampled from the pin, low requests a store |
| busy_n | output | 1 | Store line drive, low while a nonvolatile transfer runs |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, zero when not driven |
| rdata_en | output | 1 | Data outputs driven (low means high impedance) |

## Verification
The bench aims at a single-cycle store pulse that falls short of the qualification width. A design that latched it would raise busy with no real request. It issues a second hardware store straight after a first one with no write in between. A block that failed to clear its dirty mark would copy again and assert busy. It corrupts the array and then pulses reset, so a design that stored on reset or skipped recall would return the corrupt words. It also counts exact busy-low and recovery lengths, which exposes an off-by-one in any phase counter.

// File: rtl/nvk_pkg.sv
package nvk_pkg;

  typedef enum logic [2:0] {
    S_OFF, S_RECALL, S_READY, S_DRAIN, S_STORE, S_INHIBIT, S_RECOVER
  } nvk_state_e;

  typedef enum logic [1:0] {M_IDLE, M_READ, M_WRITE, M_STORE} nvk_mode_e;

  function automatic int bits_for(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  // Store line dominates, then select, then write strobe.
  function automatic nvk_mode_e decode_mode(input logic sel_n, input logic wr_n,
                                            input logic st_n);
    if (!st_n)      return M_STORE;
    else if (sel_n) return M_IDLE;
    else if (wr_n)  return M_READ;
    else            return M_WRITE;
  endfunction

endpackage

// File: rtl/nvk_mode_dec.sv
module nvk_mode_dec
  import nvk_pkg::*;
(
  input  logic sel_n,
  input  logic wr_n,
  input  logic st_line_n,
  input  logic access_ok,
  output logic rd_fire,
  output logic wr_fire
);
  nvk_mode_e mode;

  always_comb begin
    mode    = decode_mode(sel_n, wr_n, st_line_n);
    rd_fire = access_ok && (mode == M_READ);
    wr_fire = access_ok && (mode == M_WRITE);
  end
endmodule

// File: rtl/nvk_req_filter.sv
module nvk_req_filter #(
  parameter int REQ_MIN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic st_line_n,
  output logic line_high,
  output logic req_level
);
  localparam int LW = nvk_pkg::bits_for(REQ_MIN);

  logic [LW-1:0] lo_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_high <= 1'b1;
      lo_cnt    <= '0;
    end else begin
      line_high <= st_line_n;
      if (st_line_n)                    lo_cnt <= '0;
      else if (lo_cnt != LW'(REQ_MIN))  lo_cnt <= lo_cnt + 1'b1;
    end
  end

  assign req_level = (lo_cnt == LW'(REQ_MIN));

  // R4: a qualified request only exists while the sampled line is low
  a_r4_level_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
    req_level |-> !line_high);
endmodule

// File: rtl/nvk_seq.sv
module nvk_seq
  import nvk_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int DRAIN_CYC = 4,
  parameter int STORE_CYC = 80,
  parameter int RECOV_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              line_high,
  input  logic              req_level,
  input  logic              wr_fire,
  output logic              access_ok,
  output logic              busy_n,
  output logic              copy_en,
  output logic              copy_to_nv,
  output logic [ADDR_W-1:0] copy_addr
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = bits_for(max4(STORE_CYC, DEPTH, DRAIN_CYC, RECOV_CYC));

  function automatic logic at_end(input logic [CNT_W-1:0] c, input int len);
    return c == CNT_W'(len - 1);
  endfunction

  nvk_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dirty_q, pd_q, pd_d;
  logic             store_done, recall_done;

  assign store_done  = (state_q == S_STORE)  && at_end(cnt_q, STORE_CYC);
  assign recall_done = (state_q == S_RECALL) && at_end(cnt_q, DEPTH);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q + 1'b1;
    pd_d    = pd_q;
    case (state_q)
      S_OFF: begin
        cnt_d = '0;
        if (pwr_good) state_d = S_RECALL;
      end
      S_RECALL: begin
        if (!pwr_good)        state_d = S_OFF;
        else if (recall_done) state_d = S_READY;
      end
      S_READY: begin
        cnt_d = '0;
        pd_d  = 1'b0;
        if (!pwr_good) begin
          state_d = dirty_q ? S_STORE : S_OFF;
          pd_d    = 1'b1;
        end else if (req_level) begin
          state_d = dirty_q ? S_DRAIN : S_INHIBIT;
        end
      end
      S_DRAIN: begin
        if (!pwr_good) pd_d = 1'b1;
        if (at_end(cnt_q, DRAIN_CYC)) begin
          state_d = S_STORE;
          cnt_d   = '0;
        end
      end
      S_STORE: begin
        if (!pwr_good) pd_d = 1'b1;
        if (store_done) state_d = (pd_q || !pwr_good) ? S_OFF : S_INHIBIT;
      end
      S_INHIBIT: begin
        cnt_d = '0;
        if (!pwr_good)      state_d = S_OFF;
        else if (line_high) state_d = S_RECOVER;
      end
      S_RECOVER: begin
        if (!pwr_good)                     state_d = S_OFF;
        else if (at_end(cnt_q, RECOV_CYC)) state_d = S_READY;
      end
      default: state_d = S_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_OFF;
      cnt_q   <= '0;
      pd_q    <= 1'b0;
      dirty_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pd_q    <= pd_d;
      if (wr_fire)                        dirty_q <= 1'b1;
      else if (store_done || recall_done) dirty_q <= 1'b0;
    end
  end

  assign access_ok  = (state_q == S_READY) && pwr_good && !req_level;
  assign busy_n     = !((state_q == S_DRAIN) || (state_q == S_STORE) ||
                        (state_q == S_RECALL));
  assign copy_to_nv = (state_q == S_STORE);
  assign copy_en    = ((state_q == S_STORE) || (state_q == S_RECALL)) &&
                      (cnt_q < CNT_W'(DEPTH));
  assign copy_addr  = cnt_q[ADDR_W-1:0];

  // R8: an accepted write leaves the array marked unsaved
  a_r8_write_marks_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> dirty_q);
  // R8: finishing a transfer clears the unsaved mark
  a_r8_done_clears_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (store_done || recall_done) |=> !dirty_q);
  // R6: clean request is skipped without busy
  a_r6_clean_request_skips: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_READY && pwr_good && req_level && !dirty_q)
      |=> (state_q == S_INHIBIT && busy_n));
  // R9: a power-down store ends in the off state
  a_r9_pd_store_ends_off: assert property (@(posedge clk) disable iff (!rst_n)
    (store_done && pd_q) |=> (state_q == S_OFF));
endmodule

// File: rtl/nvk_mem_pair.sv
module nvk_mem_pair #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_fire,
  input  logic              wr_fire,
  input  logic              copy_en,
  input  logic              copy_to_nv,
  input  logic [ADDR_W-1:0] copy_addr,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_en
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] work_mem [DEPTH];
  logic [DATA_W-1:0] shadow_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (copy_en && copy_to_nv)  shadow_mem[copy_addr] <= work_mem[copy_addr];
    if (copy_en && !copy_to_nv) work_mem[copy_addr]   <= shadow_mem[copy_addr];
    else if (wr_fire)           work_mem[addr]        <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rdata_en <= 1'b0;
    end else begin
      rdata    <= rd_fire ? work_mem[addr] : '0;
      rdata_en <= rd_fire;
    end
  end

  // R10: bulk copy never shares a cycle with a port access
  a_r10_copy_excludes_access: assert property (@(posedge clk) disable iff (!rst_n)
    copy_en |-> !(wr_fire || rd_fire));
endmodule

// File: rtl/nvram_keeper.sv
module nvram_keeper #(
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 8,
  parameter int REQ_MIN   = 2,
  parameter int DRAIN_CYC = 4,
  parameter int STORE_CYC = 80,
  parameter int RECOV_CYC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_good,
  input  logic              sel_n,
  input  logic              wr_n,
  input  logic              st_line_n,
  output logic              busy_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              rdata_en
);
  logic              line_high, req_level, access_ok;
  logic              rd_fire, wr_fire;
  logic              copy_en, copy_to_nv;
  logic [ADDR_W-1:0] copy_addr;

  nvk_req_filter #(.REQ_MIN(REQ_MIN)) u_filt (
    .clk(clk), .rst_n(rst_n), .st_line_n(st_line_n),
    .line_high(line_high), .req_level(req_level)
  );

  nvk_mode_dec u_dec (
    .sel_n(sel_n), .wr_n(wr_n), .st_line_n(st_line_n), .access_ok(access_ok),
    .rd_fire(rd_fire), .wr_fire(wr_fire)
  );

  nvk_seq #(
    .ADDR_W(ADDR_W), .DRAIN_CYC(DRAIN_CYC),
    .STORE_CYC(STORE_CYC), .RECOV_CYC(RECOV_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .line_high(line_high),
    .req_level(req_level), .wr_fire(wr_fire), .access_ok(access_ok),
    .busy_n(busy_n), .copy_en(copy_en), .copy_to_nv(copy_to_nv),
    .copy_addr(copy_addr)
  );

  nvk_mem_pair #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .rd_fire(rd_fire), .wr_fire(wr_fire), .copy_en(copy_en),
    .copy_to_nv(copy_to_nv), .copy_addr(copy_addr),
    .rdata(rdata), .rdata_en(rdata_en)
  );

  // R5: data outputs stay undriven while busy is asserted
  a_r5_busy_blanks_data: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> !rdata_en);
  // R3: a low store line prevents the next read from driving data
  a_r3_line_low_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    !st_line_n |=> !rdata_en);
endmodule

// File: tb/nvram_keeper_tb.sv
`timescale 1ns/1ps
module nvram_keeper_tb;
  localparam int ADDR_W = 6, DATA_W = 8, REQ_MIN = 2;
  localparam int DRAIN_CYC = 4, STORE_CYC = 80, RECOV_CYC = 6;
  localparam int DEPTH = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n, pwr_good, sel_n, wr_n, st_line_n, busy_n, rdata_en;
  logic [ADDR_W-1:0] addr;
  logic [DATA_W-1:0] wdata, rdata;

  int checks = 0, errors = 0;
  logic [DATA_W-1:0] m_work [DEPTH];
  logic [DATA_W-1:0] m_shadow [DEPTH];
  bit m_dirty = 1'b0;

  always #4 clk = ~clk;

  nvram_keeper #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REQ_MIN(REQ_MIN),
    .DRAIN_CYC(DRAIN_CYC), .STORE_CYC(STORE_CYC), .RECOV_CYC(RECOV_CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .sel_n(sel_n), .wr_n(wr_n),
    .st_line_n(st_line_n), .busy_n(busy_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .rdata_en(rdata_en));

  function automatic int exp_req_delay();  return REQ_MIN + 1;          endfunction
  function automatic int exp_hw_busy();    return DRAIN_CYC + STORE_CYC; endfunction
  function automatic int exp_recover();    return RECOV_CYC + 3;        endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_write(input int a, input logic [DATA_W-1:0] d);
    sel_n = 1'b0; wr_n = 1'b0; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    sel_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic do_read(input int a, output logic en, output logic [DATA_W-1:0] d);
    sel_n = 1'b0; wr_n = 1'b1; addr = ADDR_W'(a);
    @(negedge clk);
    en = rdata_en; d = rdata;
    sel_n = 1'b1;
  endtask

  // samples until busy falls (dly = sample index), then the low run length
  task automatic measure_busy(input int limit, output int dly, output int len);
    dly = 0; len = 0;
    while (1) begin
      @(negedge clk); dly++;
      if (!busy_n) break;
      if (dly >= limit) return;
    end
    len = 1;
    while (1) begin
      @(negedge clk);
      if (busy_n) break;
      len++;
    end
  endtask

  task automatic wait_ready(input string req);
    logic en; logic [DATA_W-1:0] d;
    int tries = 0;
    en = 1'b0;
    while (!en && tries < 40) begin do_read(0, en, d); tries++; end
    chk(en, req, tries, 40);
  endtask

  task automatic compare_all(input string req);
    logic en; logic [DATA_W-1:0] d;
    int bad = 0;
    for (int a = 0; a < DEPTH; a++) begin
      do_read(a, en, d);
      if (!en || d !== m_work[a]) bad++;
    end
    chk(bad == 0, req, bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic en; logic [DATA_W-1:0] d;
    int dly, len, k;
    void'($urandom(32'd2024));
    rst_n = 1'b0; pwr_good = 1'b0; sel_n = 1'b1; wr_n = 1'b1; st_line_n = 1'b1;
    addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state and no access while power is absent
    chk(busy_n === 1'b1, "R1 busy after reset", busy_n, 1);
    do_read(0, en, d);
    chk(en === 1'b0, "R1 read while off", en, 0);

    // R10: power-up recall
    pwr_good = 1'b1;
    measure_busy(5, dly, len);
    chk(dly == 1 && len == DEPTH, "R10 recall busy length", len, DEPTH);
    m_dirty = 1'b0;

    // R2: fill with random data, read back random spots, standby
    for (int a = 0; a < DEPTH; a++) begin
      logic [DATA_W-1:0] v = DATA_W'($urandom);
      do_write(a, v); m_work[a] = v; m_dirty = 1'b1;
    end
    for (int i = 0; i < 6; i++) begin
      int a = int'($urandom % DEPTH);
      do_read(a, en, d);
      chk(en && d === m_work[a], "R2 read back", int'(d), int'(m_work[a]));
    end
    sel_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    chk(rdata_en === 1'b0, "R2 standby undriven", rdata_en, 0);

    // R4: one-cycle pulse is too short
    st_line_n = 1'b0; @(negedge clk); st_line_n = 1'b1;
    measure_busy(20, dly, len);
    chk(len == 0, "R4 short pulse ignored", len, 0);
    do_read(7, en, d);
    chk(en && d === m_work[7], "R4 access after short pulse", int'(d), int'(m_work[7]));

    // R4/R5: qualified hardware store with unsaved data
    st_line_n = 1'b0;
    measure_busy(10, dly, len);
    chk(dly == exp_req_delay(), "R4 busy latency", dly, exp_req_delay());
    chk(len == exp_hw_busy(), "R5 busy length", len, exp_hw_busy());
    for (int a = 0; a < DEPTH; a++) m_shadow[a] = m_work[a];
    m_dirty = 1'b0;

    // R3: write attempted while line low must not land
    do_write(5, ~m_work[5]);

    // R7: recovery count with a read held from the release cycle
    sel_n = 1'b0; wr_n = 1'b1; addr = ADDR_W'(5);
    st_line_n = 1'b1;
    k = 0;
    while (k < 30) begin
      @(negedge clk); k++;
      if (rdata_en) break;
    end
    chk(k == exp_recover(), "R7 recovery cycles", k, exp_recover());
    chk(rdata === m_work[5], "R3 blocked write", int'(rdata), int'(m_work[5]));
    sel_n = 1'b1;

    // R8/R6: second request with no write since the store is skipped
    st_line_n = 1'b0;
    measure_busy(20, dly, len);
    chk(len == 0, "R8 dirty cleared by store", len, 0);
    st_line_n = 1'b1;
    wait_ready("R7 ready after skipped request");

    // R11: corrupt, then abrupt reset: recall brings back the shadow
    for (int a = 0; a < DEPTH; a++) begin
      logic [DATA_W-1:0] v = DATA_W'($urandom);
      do_write(a, v); m_work[a] = v;
    end
    rst_n = 1'b0; repeat (2) @(negedge clk); rst_n = 1'b1;
    measure_busy(5, dly, len);
    chk(len == DEPTH, "R10 recall after reset", len, DEPTH);
    for (int a = 0; a < DEPTH; a++) m_work[a] = m_shadow[a];
    m_dirty = 1'b0;
    compare_all("R11 shadow restored");

    // R6: clean request, blocked write during it, shadow untouched
    st_line_n = 1'b0;
    measure_busy(20, dly, len);
    chk(len == 0, "R6 clean request no busy", len, 0);
    do_write(1, ~m_work[1]);
    st_line_n = 1'b1;
    wait_ready("R7 ready after clean request");
    do_read(1, en, d);
    chk(d === m_work[1], "R3 write ignored during request", int'(d), int'(m_work[1]));

    // R9: power-down store with unsaved writes
    for (int i = 0; i < 8; i++) begin
      int a = int'($urandom % DEPTH);
      logic [DATA_W-1:0] v = DATA_W'($urandom);
      do_write(a, v); m_work[a] = v;
    end
    pwr_good = 1'b0;
    measure_busy(5, dly, len);
    chk(dly == 1 && len == STORE_CYC, "R9 power-down store length", len, STORE_CYC);
    for (int a = 0; a < DEPTH; a++) m_shadow[a] = m_work[a];
    do_read(3, en, d);
    chk(en === 1'b0, "R1 no access while off", en, 0);
    pwr_good = 1'b1;
    measure_busy(5, dly, len);
    chk(len == DEPTH, "R10 recall after power return", len, DEPTH);
    compare_all("R10 data after power cycle");

    // R9: clean power-down skips the store
    pwr_good = 1'b0;
    measure_busy(10, dly, len);
    chk(len == 0, "R9 clean power-down no store", len, 0);
    pwr_good = 1'b1;
    measure_busy(5, dly, len);
    chk(len == DEPTH, "R10 second recall", len, DEPTH);
    compare_all("R10 data after clean power cycle");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule